// File: doc/BRIEF.md
# Virtqueue notification address decoder

This block sits on the write path into a device's notification region and decides which virtqueue, if any, a driver write is meant to wake. Software loads a per-queue table of notification slots, counted in units of a shared multiplier, together with that multiplier. Each incoming write address is compared against the window base plus each queue's slot. When a write decodes cleanly, the block raises a one-cycle notify pulse carrying the queue number. When a write lands in the window but cannot be tied to a usable queue, it raises an error flag instead.

The multiplier is held as a log2 shift amount plus a "zero" flag, so each slot address is formed by a shift. Zero mode folds every queue onto the window base. In that mode the 16-bit write datum alone names the queue. In shift mode the datum must agree with the queue that the address selects. Outputs appear on the clock edge after the write is presented.

Top module: `vq_notify_decoder`

## Requirements
- R1: After reset, notify, notify_err and mult_rej are 0, the multiplier is in zero mode and every queue is disabled, so a write at the window base is flagged as an error.
- R2: A multiplier setting is accepted when the zero flag is set, or when the shift lies in 1..MAX_SHIFT. Any other setting pulses mult_rej on the following cycle and leaves the previous setting in force.
- R3: In shift mode, a write at cfg_base + (slot << shift) that hits an enabled queue q, with wr_data == q and wr_be == 2'b11, gives notify=1 and notify_q=q on the next cycle, with notify_err=0.
- R4: When several enabled queues decode to the same address, the lowest-numbered one is selected.
- R5: In zero mode, a write at exactly cfg_base notifies the queue named by wr_data, provided that queue exists and is enabled.
- R6: In zero mode, a write in the window is an error if it names a queue that is out of range or disabled, or if it is not at offset 0.
- R7: In shift mode, a write in the window that matches no enabled queue's address is an error.
- R8: In shift mode, a write whose wr_data differs from the address-decoded queue is an error.
- R9: A write outside [cfg_base, cfg_base + cfg_len) produces neither notify nor notify_err.
- R10: A decoded queue counts only if its offset plus 2 bytes fits within cfg_len. If it does not fit, the write is an error.
- R11: A write in the window whose wr_be is not 2'b11 is an error.
- R12: notify and notify_err are never high together. Either one is high only in the cycle after a cycle with wr_valid high.
- R13: Table writes with tbl_idx >= NUM_QUEUES are ignored and create no queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W | Byte address where the notification window starts |
| cfg_len | input | ADDR_W | Window length in bytes |
| mult_we | input | 1 | Load a multiplier setting |
| mult_zero_in | input | 1 | Requested setting is multiplier zero |
| mult_shift_in | input | SW | Requested log2 of the multiplier |
| tbl_we | input | 1 | Write one queue table entry |
| tbl_idx | input | QW | Queue number for the table write |
| tbl_off | input | OFF_W | Queue slot in multiplier units |
| tbl_en | input | 1 | Queue enable for the table write |
| wr_valid | input | 1 | Driver write present |
| wr_addr | input | ADDR_W | Driver write byte address |
| wr_data | input | 16 | Notification datum (queue number) |
| wr_be | input | 2 | Byte enables of the datum |
| notify | output | 1 | One-cycle queue notification |
| notify_q | output | QW | Notified queue number |
| notify_err | output | 1 | Write in window could not be decoded |
| mult_rej | output | 1 | Previous multiplier request was refused |

## Verification
The bench builds the decoder with NUM_QUEUES=6 and MAX_SHIFT=4. With six queues, a three-bit table index and datum values of 6 and 7 exist but name no queue, which brings the out-of-range cases within reach. A shift limit of 4 makes shift 5 and shift 7 illegal, so configuration refusal can be exercised. Two queues are given the same slot to reach the priority rule, and the window length is moved by single bytes around the last queue's slot to cover the two-byte fit boundary.

// File: rtl/vqn_pkg.sv
package vqn_pkg;

  // Byte offset of a queue slot inside the window: slot units scaled by 2**shift.
  function automatic logic [63:0] slot_bytes(input logic [31:0] slot, input logic [7:0] shamt);
    return {32'b0, slot} << shamt;
  endfunction

  // A notification datum is two bytes wide; its whole span must sit in the window.
  function automatic logic room_for(input logic [63:0] at, input logic [31:0] win_len);
    return (at + 64'd2) <= {32'b0, win_len};
  endfunction

  // Legal multiplier: zero, or 2**s with 1 <= s <= max_s.
  function automatic logic mult_legal(input logic zero, input logic [7:0] s, input int max_s);
    return zero || (s >= 8'd1 && 32'(s) <= max_s);
  endfunction

endpackage

// File: rtl/vqn_mult_cfg.sv
module vqn_mult_cfg #(
  parameter int MAX_SHIFT = 12,
  parameter int SW        = $clog2(MAX_SHIFT + 1) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_we,
  input  logic          set_zero,
  input  logic [SW-1:0] set_shift,
  output logic          mult_zero,
  output logic [SW-1:0] mult_shift,
  output logic          rej
);
  import vqn_pkg::*;

  logic          zero_q;
  logic [SW-1:0] shift_q;
  logic          req_ok;

  assign req_ok = mult_legal(set_zero, 8'(set_shift), MAX_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_q  <= 1'b1;
      shift_q <= SW'(1);
      rej     <= 1'b0;
    end else begin
      rej <= set_we && !req_ok;
      if (set_we && req_ok) begin
        zero_q  <= set_zero;
        shift_q <= set_shift;
      end
    end
  end

  assign mult_zero  = zero_q;
  assign mult_shift = shift_q;

  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rej |-> ($stable(zero_q) && $stable(shift_q))); // R2
  AST_SHIFT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_q |-> (shift_q >= SW'(1) && 32'(shift_q) <= MAX_SHIFT)); // R2

endmodule

// File: rtl/vqn_queue_table.sv
module vqn_queue_table #(
  parameter int N      = 8,
  parameter int QW     = 3,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 16,
  parameter int SW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [QW-1:0]     tbl_idx,
  input  logic [OFF_W-1:0]  tbl_off,
  input  logic              tbl_en,
  input  logic [SW-1:0]     mult_shift,
  input  logic [ADDR_W-1:0] rel,
  input  logic [ADDR_W-1:0] win_len,
  output logic [N-1:0]      en_vec,
  output logic [N-1:0]      match_vec,
  output logic [N-1:0]      room_vec
);
  import vqn_pkg::*;

  for (genvar q = 0; q < N; q++) begin : g_q
    logic [OFF_W-1:0] off_q;
    logic             en_q;
    logic [63:0]      at;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_q <= '0;
        en_q  <= 1'b0;
      end else if (tbl_we && 32'(tbl_idx) == q) begin
        off_q <= tbl_off;
        en_q  <= tbl_en;
      end
    end

    assign at           = slot_bytes(32'(off_q), 8'(mult_shift));
    assign en_vec[q]    = en_q;
    assign match_vec[q] = en_q && (at == 64'(rel));
    assign room_vec[q]  = room_for(at, 32'(win_len));
  end

endmodule

// File: rtl/vqn_pick.sv
module vqn_pick #(
  parameter int N  = 8,
  parameter int QW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  match_vec,
  output logic [N-1:0]  grant,
  output logic          hit,
  output logic [QW-1:0] hit_idx
);

  always_comb begin
    grant   = '0;
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        hit      = 1'b1;
        hit_idx  = QW'(i);
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R4
  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((match_vec & (grant - N'(1))) == '0)); // R4

endmodule

// File: rtl/vq_notify_decoder.sv
module vq_notify_decoder #(
  parameter int NUM_QUEUES = 8,
  parameter int ADDR_W     = 16,
  parameter int OFF_W      = 16,
  parameter int MAX_SHIFT  = 12,
  localparam int QW        = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1,
  localparam int SW        = $clog2(MAX_SHIFT + 1) + 1,
  localparam int IDX_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_len,
  input  logic              mult_we,
  input  logic              mult_zero_in,
  input  logic [SW-1:0]     mult_shift_in,
  input  logic              tbl_we,
  input  logic [QW-1:0]     tbl_idx,
  input  logic [OFF_W-1:0]  tbl_off,
  input  logic              tbl_en,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [IDX_W-1:0]  wr_data,
  input  logic [1:0]        wr_be,
  output logic              notify,
  output logic [QW-1:0]     notify_q,
  output logic              notify_err,
  output logic              mult_rej
);
  import vqn_pkg::*;

  logic                  mult_zero;
  logic [SW-1:0]         mult_shift;
  logic [ADDR_W-1:0]     rel;
  logic                  in_win;
  logic                  be_ok;
  logic [NUM_QUEUES-1:0] en_vec, match_vec, room_vec, grant;
  logic                  hit;
  logic [QW-1:0]         hit_idx;
  logic                  zero_fire, shift_fire, fire;
  logic                  zsel_ok, shift_room;
  logic [QW-1:0]         fire_q;

  vqn_mult_cfg #(.MAX_SHIFT(MAX_SHIFT), .SW(SW)) u_mult (
    .clk(clk), .rst_n(rst_n),
    .set_we(mult_we), .set_zero(mult_zero_in), .set_shift(mult_shift_in),
    .mult_zero(mult_zero), .mult_shift(mult_shift), .rej(mult_rej)
  );

  // Window membership and the byte offset of the write inside it.
  assign rel    = wr_addr - cfg_base;
  assign in_win = wr_valid && (wr_addr >= cfg_base) && (rel < cfg_len);
  assign be_ok  = &wr_be;

  vqn_queue_table #(.N(NUM_QUEUES), .QW(QW), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .SW(SW)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_off(tbl_off), .tbl_en(tbl_en),
    .mult_shift(mult_shift), .rel(rel), .win_len(cfg_len),
    .en_vec(en_vec), .match_vec(match_vec), .room_vec(room_vec)
  );

  vqn_pick #(.N(NUM_QUEUES), .QW(QW)) u_pick (
    .clk(clk), .rst_n(rst_n),
    .match_vec(match_vec), .grant(grant), .hit(hit), .hit_idx(hit_idx)
  );

  // Zero mode: the datum names the queue; it must exist and be enabled.
  always_comb begin
    zsel_ok = 1'b0;
    for (int i = 0; i < NUM_QUEUES; i++)
      if (wr_data == IDX_W'(i) && en_vec[i]) zsel_ok = 1'b1;
  end

  assign shift_room = |(grant & room_vec);
  assign zero_fire  = (rel == '0) && room_for(64'd0, 32'(cfg_len)) && zsel_ok;
  assign shift_fire = hit && shift_room && (wr_data == IDX_W'(hit_idx));
  assign fire       = be_ok && (mult_zero ? zero_fire : shift_fire);
  assign fire_q     = mult_zero ? wr_data[QW-1:0] : hit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notify     <= 1'b0;
      notify_q   <= '0;
      notify_err <= 1'b0;
    end else begin
      notify     <= in_win && fire;
      notify_err <= in_win && !fire;
      if (in_win && fire) notify_q <= fire_q;
    end
  end

  AST_NO_DUAL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !(notify && notify_err)); // R12
  AST_OUT_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (notify || notify_err) |-> $past(wr_valid)); // R12
  AST_OUTSIDE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !in_win) |=> !(notify || notify_err)); // R9
  AST_NOTIFY_Q_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    notify |-> (32'(notify_q) < NUM_QUEUES)); // R3

endmodule

// File: tb/sim_vq_notify_decoder.sv
module sim_vq_notify_decoder;
  localparam int NQ   = 6;
  localparam int AW   = 16;
  localparam int OW   = 16;
  localparam int MAXS = 4;
  localparam int QW   = $clog2(NQ);
  localparam int SW   = $clog2(MAXS + 1) + 1;

  logic          clk = 0, rst_n = 0;
  logic [AW-1:0] cfg_base = 16'h0100, cfg_len = 16'h0040;
  logic          mult_we = 0, mult_zero_in = 0;
  logic [SW-1:0] mult_shift_in = '0;
  logic          tbl_we = 0, tbl_en = 0;
  logic [QW-1:0] tbl_idx = '0;
  logic [OW-1:0] tbl_off = '0;
  logic          wr_valid = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [1:0]    wr_be = '0;
  logic          notify, notify_err, mult_rej;
  logic [QW-1:0] notify_q;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    bit n;
    int q;
    bit e;
    int req;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  vq_notify_decoder #(.NUM_QUEUES(NQ), .ADDR_W(AW), .OFF_W(OW), .MAX_SHIFT(MAXS)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_len(cfg_len),
    .mult_we(mult_we), .mult_zero_in(mult_zero_in), .mult_shift_in(mult_shift_in),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_off(tbl_off), .tbl_en(tbl_en),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .notify(notify), .notify_q(notify_q), .notify_err(notify_err), .mult_rej(mult_rej)
  );

  task automatic check(input bit ok, input int req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Driver: present one write for a single edge and queue the expected outcome.
  task automatic drv_wr(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be,
                        input bit en, input int eq, input bit ee, input int req);
    exp_t it;
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data = d; wr_be = be;
    it.n = en; it.q = eq; it.e = ee; it.req = req;
    exp_q.push_back(it);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic set_tbl(input int idx, input int off, input bit en);
    @(negedge clk);
    tbl_we = 1; tbl_idx = QW'(idx); tbl_off = OW'(off); tbl_en = en;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic set_mult(input bit z, input int sh, input bit exp_rej, input int req);
    @(negedge clk);
    mult_we = 1; mult_zero_in = z; mult_shift_in = SW'(sh);
    @(posedge clk);
    #1;
    check(mult_rej == exp_rej, req, "mult_rej", int'(mult_rej), int'(exp_rej));
    @(negedge clk);
    mult_we = 0;
  endtask

  // Monitor: outputs for a write appear after the edge that captured it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        check(notify == it.n, it.req, "notify", int'(notify), int'(it.n));
        check(notify_err == it.e, it.req, "notify_err", int'(notify_err), int'(it.e));
        if (it.n) check(int'(notify_q) == it.q, it.req, "notify_q", int'(notify_q), it.q);
        check(!(notify && notify_err), 12, "dual output", 1, 0);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(notify == 0, 1, "notify after reset", int'(notify), 0);
    check(notify_err == 0, 1, "err after reset", int'(notify_err), 0);
    check(mult_rej == 0, 1, "mult_rej after reset", int'(mult_rej), 0);
    drv_wr(16'h0100, 16'd0, 2'b11, 0, 0, 1, 1);  // R1 zero mode, no queue enabled

    set_tbl(0, 0, 1); set_tbl(1, 1, 1); set_tbl(2, 2, 1);
    set_tbl(3, 3, 1); set_tbl(4, 2, 1); set_tbl(5, 5, 0);

    drv_wr(16'h0100, 16'd3, 2'b11, 1, 3, 0, 5);  // R5
    drv_wr(16'h0100, 16'd0, 2'b11, 1, 0, 0, 5);  // R5
    drv_wr(16'h0100, 16'd5, 2'b11, 0, 0, 1, 6);  // R6 disabled queue
    drv_wr(16'h0100, 16'd7, 2'b11, 0, 0, 1, 6);  // R6 out of range
    drv_wr(16'h0104, 16'd1, 2'b11, 0, 0, 1, 6);  // R6 nonzero offset

    set_mult(0, 0, 1, 2);                          // R2 multiplier 1 is odd
    set_mult(0, 5, 1, 2);                          // R2 above MAX_SHIFT
    set_mult(0, 2, 0, 2);                          // R2 multiplier 4 accepted

    drv_wr(16'h0104, 16'd1, 2'b11, 1, 1, 0, 3);  // R3
    drv_wr(16'h010C, 16'd3, 2'b11, 1, 3, 0, 3);  // R3
    drv_wr(16'h0100, 16'd0, 2'b11, 1, 0, 0, 3);  // R3 slot 0
    drv_wr(16'h0108, 16'd2, 2'b11, 1, 2, 0, 4);  // R4 queues 2 and 4 share slot
    drv_wr(16'h0108, 16'd4, 2'b11, 0, 0, 1, 8);  // R8 datum mismatch
    drv_wr(16'h0106, 16'd1, 2'b11, 0, 0, 1, 7);  // R7 no slot at 6
    drv_wr(16'h0140, 16'd1, 2'b11, 0, 0, 0, 9);  // R9 one past window
    drv_wr(16'h00FE, 16'd0, 2'b11, 0, 0, 0, 9);  // R9 below base
    drv_wr(16'h0104, 16'd1, 2'b01, 0, 0, 1, 11); // R11 partial byte enables

    set_mult(0, 7, 1, 2);                          // R2 rejected
    drv_wr(16'h0104, 16'd1, 2'b11, 1, 1, 0, 2);  // R2 shift 2 still in force

    set_tbl(5, 15, 1);                             // slot 60
    cfg_len = 16'h003D;
    drv_wr(16'h013C, 16'd5, 2'b11, 0, 0, 1, 10); // R10 60+2 > 61
    cfg_len = 16'h003E;
    drv_wr(16'h013C, 16'd5, 2'b11, 1, 5, 0, 10); // R10 60+2 == 62 fits
    cfg_len = 16'h0040;

    set_tbl(6, 7, 1);                              // R13 ignored, slot 28 stays empty
    drv_wr(16'h011C, 16'd6, 2'b11, 0, 0, 1, 13); // R13
    set_mult(1, 0, 0, 2);                          // R2 zero mode accepted
    drv_wr(16'h0100, 16'd6, 2'b11, 0, 0, 1, 13); // R13 no queue 6
    drv_wr(16'h0100, 16'd5, 2'b11, 1, 5, 0, 5);  // R5

    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule